// File: doc/BRIEF.md
# Load-Use Stall Controller

This block sits at the decode stage of a five-stage in-order pipeline. It finds the case where the instruction in decode reads a register that a load still in execute has not yet produced. It then holds the front of the pipeline for one cycle and puts an empty slot into execute. The load and everything older carry on. After the empty slot, operand forwarding is expected to supply the loaded value, so the block keeps no history and inserts exactly one cycle per dependent pair.

The top module includes a small model of the two pipeline registers it controls, so that it can be exercised on its own. The fetch side presents the source register indices and the control bundle of the next instruction, already decoded. The fetch-to-decode register takes them while its write enable is high. The decode-to-execute register takes the control bundle, forced to all zeros during a stall, together with the decoded destination index. The fetch side is expected to hold its program counter whenever the PC write enable is low. All pins are plain control and data signals, with no stream handshake: a stall is the only form of back-pressure, and it is reported through the two write enables.

Top module: `load_use_stall_unit`

## Requirements
- R1: `rst` is synchronous and active high. While it is sampled high, both pipeline registers clear to zero. On the next falling edge, `ex_ctrl` and `ex_rt` read zero and `pc_we` and `fd_we` read 1.
- R2: When there is no stall, a fetched instruction reaches `ex_ctrl` and `ex_rt` unchanged two rising edges after it is presented: one edge into the fetch/decode register and one into decode/execute.
- R3: A stall is raised when the execute-stage instruction has its memory-read bit set and its `ex_rt` equals either the Rs or the Rt index held in fetch/decode. Index 0 is compared like any other index.
- R4: `pc_we` and `fd_we` are low in exactly the cycles in which the R3 condition holds, and high in all other cycles.
- R5: While `fd_we` is low, the fetch/decode register holds its contents. The held instruction enters execute on the edge that follows the stall cycle, with its control bundle and Rt unchanged.
- R6: The decode/execute register loads all nine control bits as zero on the edge that closes a stall cycle, whatever the decoder supplies.
- R7: Because the bubble's memory-read bit is zero, every dependent load/use pair costs exactly one stall cycle. This includes two loads in a row where the second uses the first and the next instruction uses the second.
- R8: No stall occurs when the producer in execute does not read memory, when the instruction after a load is independent of it, or when the dependent instruction comes two slots after the load.
- R9: The control bundle is 9 bits wide, with fields from MSB to LSB: register-destination select [8], ALU operation [7:6], ALU source select [5], branch [4], memory read [3], memory write [2], register write [1], memory-to-register [0]. Bit 3 is the one that R3 tests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_rs | input | REG_W | Rs index of the instruction being fetched |
| fetch_rt | input | REG_W | Rt index of the instruction being fetched |
| fetch_ctrl | input | 9 | Decoded control bundle of the instruction being fetched |
| pc_we | output | 1 | PC write enable, low during a stall |
| fd_we | output | 1 | Fetch/decode register write enable, low during a stall |
| ex_ctrl | output | 9 | Control bundle held in decode/execute |
| ex_rt | output | REG_W | Rt index held in decode/execute |

## Verification
Each instruction the bench presents at a falling edge should appear on `ex_ctrl` and `ex_rt` at the falling edge two rising edges later, with one more cycle for each bubble placed ahead of it. The write enables are combinational from the two registers. They therefore drop in the cycle after the dependent instruction has been latched into decode, which is the same cycle in which the load sits in execute. The bench builds the expected execute-stage stream from the program, placing a bubble before each dependent instruction. At every falling edge it pops one item. It compares that item with the execute outputs and compares the enables with whether the next queued item is a bubble, so every check lands in the cycle its result is due.

// File: rtl/lus_pkg.sv
package lus_pkg;

  // Control bundle produced by the main decoder; MSB first.
  typedef struct packed {
    logic       reg_dst;
    logic [1:0] alu_op;
    logic       alu_src;
    logic       branch;
    logic       mem_read;
    logic       mem_write;
    logic       reg_write;
    logic       mem_to_reg;
  } ctrl_t;

  localparam int    CTRL_W   = $bits(ctrl_t);
  localparam int    MEMRD_BIT = 3;
  localparam ctrl_t CTRL_NOP = '0;

endpackage

// File: rtl/lus_stage_reg.sv
module lus_stage_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/lus_hazard_detect.sv
module lus_hazard_detect #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                          ex_mem_read,
  input  logic [REG_W-1:0]              ex_dst,
  input  logic [NUM_SRC-1:0][REG_W-1:0] id_src,
  output logic                          hazard
);

  logic [NUM_SRC-1:0] hit;

  // one comparator per source operand of the decode-stage instruction
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign hit[g] = (id_src[g] == ex_dst);
  end

  assign hazard = ex_mem_read & (|hit);

endmodule

// File: rtl/lus_ctrl_gate.sv
module lus_ctrl_gate
  import lus_pkg::*;
(
  input  ctrl_t dec_ctrl,
  input  logic  squash,
  output ctrl_t gated_ctrl
);

  always_comb begin
    gated_ctrl = squash ? CTRL_NOP : dec_ctrl;
  end

endmodule

// File: rtl/load_use_stall_unit.sv
module load_use_stall_unit
  import lus_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  fetch_rs,
  input  logic [REG_W-1:0]  fetch_rt,
  input  logic [CTRL_W-1:0] fetch_ctrl,
  output logic              pc_we,
  output logic              fd_we,
  output logic [CTRL_W-1:0] ex_ctrl,
  output logic [REG_W-1:0]  ex_rt
);

  localparam int NUM_SRC = 2;
  localparam int IFID_W  = CTRL_W + NUM_SRC * REG_W;
  localparam int IDEX_W  = CTRL_W + REG_W;

  logic [IFID_W-1:0] ifid_d, ifid_q;
  logic [IDEX_W-1:0] idex_d, idex_q;

  ctrl_t             id_ctrl;
  logic [REG_W-1:0]  id_rs, id_rt;
  ctrl_t             ex_ctrl_s;
  ctrl_t             gated_ctrl;
  logic [REG_W-1:0]  ex_rt_s;
  logic              stall;

  // fetch/decode register: frozen while a stall is active
  assign ifid_d = {fetch_ctrl, fetch_rs, fetch_rt};

  lus_stage_reg #(.W(IFID_W)) u_ifid (
    .clk (clk),
    .rst (rst),
    .en  (fd_we),
    .d   (ifid_d),
    .q   (ifid_q)
  );

  assign id_ctrl = ctrl_t'(ifid_q[IFID_W-1 -: CTRL_W]);
  assign id_rs   = ifid_q[2*REG_W-1 -: REG_W];
  assign id_rt   = ifid_q[REG_W-1:0];

  // compare the load destination in execute against both decode sources
  lus_hazard_detect #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_haz (
    .ex_mem_read (ex_ctrl_s.mem_read),
    .ex_dst      (ex_rt_s),
    .id_src      ({id_rs, id_rt}),
    .hazard      (stall)
  );

  assign pc_we = ~stall;
  assign fd_we = ~stall;

  // bubble insertion: zero every control field entering execute
  lus_ctrl_gate u_gate (
    .dec_ctrl   (id_ctrl),
    .squash     (stall),
    .gated_ctrl (gated_ctrl)
  );

  // decode/execute register: always advances so older work keeps moving
  assign idex_d = {gated_ctrl, id_rt};

  lus_stage_reg #(.W(IDEX_W)) u_idex (
    .clk (clk),
    .rst (rst),
    .en  (1'b1),
    .d   (idex_d),
    .q   (idex_q)
  );

  assign ex_ctrl_s = ctrl_t'(idex_q[IDEX_W-1 -: CTRL_W]);
  assign ex_rt_s   = idex_q[REG_W-1:0];

  assign ex_ctrl = ex_ctrl_s;
  assign ex_rt   = ex_rt_s;

endmodule

// File: rtl/lus_checker.sv
module lus_checker #(
  parameter int REG_W  = 5,
  parameter int CTRL_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              pc_we,
  input logic              fd_we,
  input logic [REG_W-1:0]  id_rs,
  input logic [REG_W-1:0]  id_rt,
  input logic [CTRL_W-1:0] id_ctrl,
  input logic [CTRL_W-1:0] ex_ctrl,
  input logic [REG_W-1:0]  ex_rt
);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (ex_ctrl == '0 && ex_rt == '0 && pc_we && fd_we));

  assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
    pc_we |=> (ex_ctrl == $past(id_ctrl) && ex_rt == $past(id_rt)));

  assert_enables_R4: assert property (@(posedge clk) disable iff (rst)
    pc_we == fd_we);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !fd_we |=> ($stable(id_rs) && $stable(id_rt) && $stable(id_ctrl)));

  assert_bubble_R6: assert property (@(posedge clk) disable iff (rst)
    !pc_we |=> (ex_ctrl == '0));

  assert_single_R7: assert property (@(posedge clk) disable iff (rst)
    !pc_we |=> pc_we);

  assert_noload_R8: assert property (@(posedge clk) disable iff (rst)
    !ex_ctrl[lus_pkg::MEMRD_BIT] |-> pc_we);

endmodule

bind load_use_stall_unit lus_checker #(.REG_W(REG_W), .CTRL_W(lus_pkg::CTRL_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pc_we   (pc_we),
  .fd_we   (fd_we),
  .id_rs   (id_rs),
  .id_rt   (id_rt),
  .id_ctrl (id_ctrl),
  .ex_ctrl (ex_ctrl),
  .ex_rt   (ex_rt)
);

// File: tb/tb_load_use_stall_unit.sv
`timescale 1ns/1ps
module tb_load_use_stall_unit;

  localparam int RW = 5;

  // control encodings per R9: [8]dst [7:6]aluop [5]src [4]br [3]mrd [2]mwr [1]rwr [0]m2r
  localparam logic [8:0] C_LW  = 9'h02B;
  localparam logic [8:0] C_RT  = 9'h182;
  localparam logic [8:0] C_SW  = 9'h024;
  localparam logic [8:0] C_BEQ = 9'h050;
  localparam logic [8:0] C_ALL = 9'h1FF;
  localparam logic [8:0] C_NOP = 9'h000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [RW-1:0] fetch_rs = '0, fetch_rt = '0;
  logic [8:0]    fetch_ctrl = '0;
  logic          pc_we, fd_we;
  logic [8:0]    ex_ctrl;
  logic [RW-1:0] ex_rt;

  load_use_stall_unit #(.REG_W(RW)) dut (
    .clk(clk), .rst(rst), .fetch_rs(fetch_rs), .fetch_rt(fetch_rt),
    .fetch_ctrl(fetch_ctrl), .pc_we(pc_we), .fd_we(fd_we),
    .ex_ctrl(ex_ctrl), .ex_rt(ex_rt)
  );

  always #2.5 clk = ~clk;

  typedef struct { logic [8:0] ctrl; logic [RW-1:0] rt; logic bubble; } item_t;
  item_t q[$];

  logic [8:0]    p_ctrl [64];
  logic [RW-1:0] p_rs [64], p_rt [64];
  int            n_prog = 0;
  logic [8:0]    prev_ctrl = C_NOP;
  logic [RW-1:0] prev_rt = '0;
  int            exp_bubbles = 0;
  int            seen_stalls = 0;
  int            nvec = 0, nbad = 0;
  int            pc = 0;
  bit            done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver side: records the instruction and pushes the execute-stage items it must produce
  task automatic add_instr(logic [8:0] c, logic [RW-1:0] rs, logic [RW-1:0] rt);
    item_t it;
    p_ctrl[n_prog] = c; p_rs[n_prog] = rs; p_rt[n_prog] = rt; n_prog++;
    if (prev_ctrl[3] && (prev_rt == rs || prev_rt == rt)) begin
      it.ctrl = C_NOP; it.rt = '0; it.bubble = 1'b1;
      q.push_back(it);
      exp_bubbles++;
    end
    it.ctrl = c; it.rt = rt; it.bubble = 1'b0;
    q.push_back(it);
    prev_ctrl = c; prev_rt = rt;
  endtask

  initial begin
    item_t r;
    // execute register after reset, then the cleared fetch/decode content (R1)
    r.ctrl = C_NOP; r.rt = '0; r.bubble = 1'b0;
    q.push_back(r);
    q.push_back(r);
    add_instr(C_LW, 5'd2, 5'd5);  add_instr(C_RT, 5'd5, 5'd6);  // R3 Rs match
    add_instr(C_LW, 5'd2, 5'd6);  add_instr(C_RT, 5'd1, 5'd6);  // R3 Rt match
    add_instr(C_LW, 5'd2, 5'd7);  add_instr(C_RT, 5'd1, 5'd2);  // R8 independent
    add_instr(C_LW, 5'd2, 5'd8);  add_instr(C_RT, 5'd1, 5'd2);
    add_instr(C_RT, 5'd8, 5'd8);                                // R8 distance two
    add_instr(C_RT, 5'd1, 5'd9);  add_instr(C_RT, 5'd9, 5'd9);  // R8 producer not a load
    add_instr(C_LW, 5'd2, 5'd3);  add_instr(C_LW, 5'd3, 5'd4);
    add_instr(C_RT, 5'd4, 5'd4);                                // R7 chained loads
    add_instr(C_LW, 5'd2, 5'd10); add_instr(C_SW, 5'd1, 5'd10); // R5 store held
    add_instr(C_ALL, 5'd0, 5'd11); add_instr(C_ALL, 5'd11, 5'd0); // R6 R9 full bundle
    add_instr(C_BEQ, 5'd11, 5'd12);
    add_instr(C_LW, 5'd2, 5'd0);  add_instr(C_RT, 5'd0, 5'd0);  // R3 index zero
    for (int i = 0; i < 3; i++) add_instr(C_NOP, 5'd31, 5'd30);

    // reset with a live load on the fetch side: nothing may pass (R1)
    fetch_ctrl = p_ctrl[0]; fetch_rs = p_rs[0]; fetch_rt = p_rt[0];
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ex_ctrl in reset", 32'(ex_ctrl), 32'(C_NOP));
    chk("R1 ex_rt in reset", 32'(ex_rt), 32'd0);
    chk("R1 pc_we in reset", 32'(pc_we), 32'd1);
    chk("R1 fd_we in reset", 32'(fd_we), 32'd1);
    rst = 1'b0;

    // instruction-memory model: the counter advances only when pc_we is high
    fork
      forever begin
        logic we;
        if (pc < n_prog) begin
          fetch_ctrl = p_ctrl[pc]; fetch_rs = p_rs[pc]; fetch_rt = p_rt[pc];
        end else begin
          fetch_ctrl = C_NOP; fetch_rs = 5'd31; fetch_rt = 5'd30;
        end
        we = pc_we;
        @(posedge clk);
        if (we) pc++;
        @(negedge clk);
      end
    join_none

    // monitor: one execute-stage item per falling edge
    while (q.size() >= 2) begin
      item_t cur;
      logic  stall_due;
      cur = q.pop_front();
      stall_due = q[0].bubble;
      if (cur.bubble) begin
        chk("R6 bubble ex_ctrl", 32'(ex_ctrl), 32'(C_NOP));
      end else begin
        chk("R2/R5 ex_ctrl", 32'(ex_ctrl), 32'(cur.ctrl));
        chk("R2/R5 ex_rt", 32'(ex_rt), 32'(cur.rt));
      end
      chk(stall_due ? "R3 pc_we" : "R4/R8 pc_we", 32'(pc_we), 32'(!stall_due));
      chk("R4 fd_we", 32'(fd_we), 32'(!stall_due));
      if (!pc_we) seen_stalls++;
      @(negedge clk);
    end
    chk("R7 stall cycle count", 32'(seen_stalls), 32'(exp_bubbles));
    chk("R7 pairs in program", 32'(exp_bubbles), 32'd7);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule